// File: doc/BRIEF.md
# Receive-Line Idle and Character Wake Detector

This block sits behind a serial receiver and decides when a sleeping system should be woken. It watches two things: the raw receive line, and the characters that the receiver has already decoded. In idle-line mode it counts whole character periods of a continuously high line. When that count reaches a programmed length of 1 to 128 characters, it reports the idle condition and issues a wake pulse. In address-mark mode it wakes only for a character whose top bit, the address mark, is set. In data-match mode it wakes when a character equals either of two programmed compare values. A fourth mode disables the wake output.

One character period is the start bit plus the configured data bits (7 to 10) plus one or two stop bits, counted in receiver bit ticks. Any low level on the line restarts the idle count. After the idle condition has been reported, the timer stays parked until at least one character has been received. This stops a long quiet line from producing repeated wake pulses.

Characters arrive on a valid/ready stream. The block accepts one character in every cycle, so `chr_ready` is high whenever reset is released and there is never back-pressure. A character is taken in each cycle where `chr_valid` and `chr_ready` are both high.

Top module: `uart_wake_detect`

## Requirements
- R1: While reset is held and in the first cycle after it, `wake` and `idle_flag` are 0. `chr_ready` is 1 whenever reset is released.
- R2: A character period is 1 + `data_bits` + (`two_stop` ? 2 : 1) bit ticks. `idle_flag` rises in the cycle after the bit tick that completes 2^`idle_sel` character periods of continuously high line (`idle_sel` = 0..7 selects 1..128).
- R3: A low level on `rx_line` in any cycle restarts the idle count from zero.
- R4: In idle-line mode (`mode` = 2'b00), `wake` is a one-cycle pulse in the same cycle that `idle_flag` rises. Received characters do not cause a wake in this mode.
- R5: After `idle_flag` rises it stays high, and no new idle detection or wake can occur, until a character is accepted. An accepted character clears `idle_flag` in the next cycle and restarts the idle count from zero.
- R6: In address-mark mode (`mode` = 2'b01), `wake` is high in the cycle after a character is accepted with bit 8 of `chr_data` set, and only then.
- R7: In data-match mode (`mode` = 2'b10), `wake` is high in the cycle after an accepted character equals `match_a` or `match_b` over all 9 bits, and only then.
- R8: With `mode` = 2'b11, `wake` stays 0, while `idle_flag` still follows R2.
- R9: While `bit_tick` is low, the idle count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One pulse per receive bit period |
| rx_line | input | 1 | Receive line level (1 = idle) |
| chr_valid | input | 1 | Decoded character present |
| chr_ready | output | 1 | Block accepts a character (always high out of reset) |
| chr_data | input | 9 | Decoded character; bit 8 is the address mark |
| mode | input | 2 | 00 idle, 01 address mark, 10 data match, 11 off |
| idle_sel | input | 3 | Idle length select, 2^idle_sel characters |
| data_bits | input | 4 | Data bits per character, 7 to 10 |
| two_stop | input | 1 | 1 = two stop bits |
| match_a | input | 9 | First compare value |
| match_b | input | 9 | Second compare value |
| wake | output | 1 | Wake event pulse |
| idle_flag | output | 1 | Idle condition detected |

## Verification
Character-based results (R6, R7, R8) are due one clock after the accepting edge. The bench drives each character at a falling edge and samples `wake` at the next falling edge. The idle result is due on the Nth ticked rising edge after the line goes high, where N is the character length times 2^`idle_sel`. The bench therefore counts N-1 falling edges, checks that the flag is still low, and then checks that the flag and the wake pulse appear one edge later. The restart, re-arm and tick-freeze cases use the same counting, starting from the edge where the line or a character resets the count.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    WM_IDLE  = 2'b00,
    WM_ADDR  = 2'b01,
    WM_MATCH = 2'b10,
    WM_OFF   = 2'b11
  } wake_mode_e;
endpackage

// File: rtl/wake_idle_timer.sv
module wake_idle_timer #(
  parameter int SEL_W = 3,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_line,
  input  logic             chr_take,
  input  logic [3:0]       data_bits,
  input  logic             two_stop,
  input  logic [SEL_W-1:0] idle_sel,
  output logic             idle_hit,
  output logic             idle_flag
);
  localparam int MAX_CHARS = 1 << ((1 << SEL_W) - 1);
  localparam int CNT_W     = $clog2(MAX_CHARS) + 1;

  logic [LEN_W-1:0] char_len;
  logic [LEN_W-1:0] bit_cnt;
  logic [CNT_W-1:0] char_cnt;
  logic [CNT_W-1:0] target;
  logic             armed;
  logic             char_end;

  assign char_len = LEN_W'(1) + LEN_W'(data_bits) + (two_stop ? LEN_W'(2) : LEN_W'(1));
  assign target   = CNT_W'(1) << idle_sel;
  assign char_end = bit_tick && rx_line && armed && (bit_cnt == char_len - LEN_W'(1));
  assign idle_hit = char_end && (char_cnt == target - CNT_W'(1)) && !chr_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      char_cnt  <= '0;
      armed     <= 1'b1;
      idle_flag <= 1'b0;
    end else if (chr_take) begin
      bit_cnt   <= '0;
      char_cnt  <= '0;
      armed     <= 1'b1;
      idle_flag <= 1'b0;
    end else if (!rx_line) begin
      bit_cnt  <= '0;
      char_cnt <= '0;
    end else if (bit_tick && armed) begin
      if (char_end) begin
        bit_cnt <= '0;
        if (idle_hit) begin
          char_cnt  <= '0;
          armed     <= 1'b0;
          idle_flag <= 1'b1;
        end else begin
          char_cnt <= char_cnt + CNT_W'(1);
        end
      end else begin
        bit_cnt <= bit_cnt + LEN_W'(1);
      end
    end
  end

  // R3
  low_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_line |=> (bit_cnt == '0 && char_cnt == '0));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_flag && !chr_take) |=> idle_flag);

  // R2
  flag_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> $past(rx_line && bit_tick));
endmodule

// File: rtl/wake_char_match.sv
module wake_char_match #(
  parameter int DATA_W    = 9,
  parameter int NUM_MATCH = 2
) (
  input  logic [DATA_W-1:0]                chr_data,
  input  logic [NUM_MATCH-1:0][DATA_W-1:0] match_vals,
  output logic                             addr_hit,
  output logic                             data_hit
);
  logic [NUM_MATCH-1:0] hits;

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_cmp
    assign hits[i] = (chr_data == match_vals[i]);
  end

  assign data_hit = |hits;
  assign addr_hit = chr_data[DATA_W-1];
endmodule

// File: rtl/uart_wake_detect.sv
module uart_wake_detect
  import wake_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              rx_line,
  input  logic              chr_valid,
  output logic              chr_ready,
  input  logic [DATA_W-1:0] chr_data,
  input  logic [1:0]        mode,
  input  logic [SEL_W-1:0]  idle_sel,
  input  logic [3:0]        data_bits,
  input  logic              two_stop,
  input  logic [DATA_W-1:0] match_a,
  input  logic [DATA_W-1:0] match_b,
  output logic              wake,
  output logic              idle_flag
);
  localparam int NUM_MATCH = 2;
  localparam int LEN_W     = 5;

  wake_mode_e mode_e;
  logic       chr_take;
  logic       idle_hit;
  logic       addr_hit;
  logic       data_hit;
  logic       wake_d;
  logic [NUM_MATCH-1:0][DATA_W-1:0] match_vals;

  assign mode_e     = wake_mode_e'(mode);
  assign chr_ready  = rst_n;
  assign chr_take   = chr_valid && chr_ready;
  assign match_vals = {match_b, match_a};

  wake_idle_timer #(.SEL_W(SEL_W), .LEN_W(LEN_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .rx_line   (rx_line),
    .chr_take  (chr_take),
    .data_bits (data_bits),
    .two_stop  (two_stop),
    .idle_sel  (idle_sel),
    .idle_hit  (idle_hit),
    .idle_flag (idle_flag)
  );

  wake_char_match #(.DATA_W(DATA_W), .NUM_MATCH(NUM_MATCH)) u_match (
    .chr_data   (chr_data),
    .match_vals (match_vals),
    .addr_hit   (addr_hit),
    .data_hit   (data_hit)
  );

  always_comb begin
    unique case (mode_e)
      WM_IDLE:  wake_d = idle_hit;
      WM_ADDR:  wake_d = chr_take && addr_hit;
      WM_MATCH: wake_d = chr_take && data_hit;
      default:  wake_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= wake_d;
  end

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($past(mode) != 2'b11));

  // R6
  addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && $past(mode) == 2'b01) |-> $past(chr_valid && chr_data[DATA_W-1]));

  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && $past(mode) == 2'b00) |-> $rose(idle_flag));
endmodule

// File: tb/sim_uart_wake_detect.sv
module sim_uart_wake_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       rx_line = 1'b0;
  logic       chr_valid = 1'b0;
  logic       chr_ready;
  logic [8:0] chr_data = '0;
  logic [1:0] mode = 2'b11;
  logic [2:0] idle_sel = '0;
  logic [3:0] data_bits = 4'd8;
  logic       two_stop = 1'b0;
  logic [8:0] match_a = 9'h055;
  logic [8:0] match_b = 9'h1A3;
  logic       wake;
  logic       idle_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_wake_detect u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
    .chr_valid(chr_valid), .chr_ready(chr_ready), .chr_data(chr_data),
    .mode(mode), .idle_sel(idle_sel), .data_bits(data_bits), .two_stop(two_stop),
    .match_a(match_a), .match_b(match_b), .wake(wake), .idle_flag(idle_flag)
  );

  // {mode, data, expected wake}
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {2'b01, 9'h100, 1'b1}, {2'b01, 9'h0FF, 1'b0}, {2'b01, 9'h1A3, 1'b1},
    {2'b10, 9'h055, 1'b1}, {2'b10, 9'h1A3, 1'b1}, {2'b10, 9'h056, 1'b0},
    {2'b10, 9'h155, 1'b0}, {2'b00, 9'h155, 1'b0}, {2'b11, 9'h100, 1'b0},
    {2'b11, 9'h055, 1'b0}
  };

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic send_char(input logic [8:0] d);
    @(negedge clk);
    chr_data  = d;
    chr_valid = 1'b1;
    @(negedge clk);
    chr_valid = 1'b0;
  endtask

  // line is held low on entry; raise it and expect idle after n ticked edges
  task automatic idle_run(input int n, input string req);
    @(negedge clk);
    rx_line = 1'b1;
    for (int i = 0; i < n - 1; i++) @(negedge clk);
    check(req, idle_flag, 1'b0);
    @(negedge clk);
    check(req, idle_flag, 1'b1);
    check(req, wake, mode == 2'b00);
    @(negedge clk);
    check(req, wake, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 wake in reset", wake, 1'b0);
    check("R1 flag in reset", idle_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wake after reset", wake, 1'b0);
    check("R1 flag after reset", idle_flag, 1'b0);
    check("R1 ready", chr_ready, 1'b1);

    // table of characters, line held low so the idle count stays at zero
    for (int k = 0; k < NV; k++) begin
      mode = VEC[k][11:10];
      send_char(VEC[k][9:1]);
      check(k < 3 ? "R6 addr" : (k < 7 ? "R7 match" : (k < 8 ? "R4 idle char" : "R8 off")),
            wake, VEC[k][0]);
    end

    // R2 / R4: 8 data, 1 stop, one character -> 10 ticks
    bit_tick = 1'b1;
    mode = 2'b00;
    idle_run(10, "R2 R4 idle 1x10");

    // R5: no refire while parked, even with the line high for long
    repeat (40) begin
      @(negedge clk);
      check("R5 parked wake", wake, 1'b0);
    end
    check("R5 flag held", idle_flag, 1'b1);
    rx_line = 1'b0;
    send_char(9'h155);
    check("R5 char clears flag", idle_flag, 1'b0);
    check("R4 char no wake", wake, 1'b0);

    // R2: 9 data, 2 stop -> 12 ticks, 4 characters -> 48
    data_bits = 4'd9; two_stop = 1'b1; idle_sel = 3'd2;
    idle_run(48, "R2 idle 4x12");

    // R5 re-arm: char with line high, count restarts from the accepting edge
    data_bits = 4'd8; two_stop = 1'b0; idle_sel = 3'd0;
    send_char(9'h000);
    check("R5 rearm clear", idle_flag, 1'b0);
    for (int i = 0; i < 9; i++) @(negedge clk);
    check("R5 rearm early", idle_flag, 1'b0);
    @(negedge clk);
    check("R5 rearm fire", idle_flag, 1'b1);
    check("R5 rearm wake", wake, 1'b1);

    // R3: low glitch restarts count (20 ticks needed)
    rx_line = 1'b0;
    send_char(9'h000);
    idle_sel = 3'd1;
    rx_line = 1'b1;
    repeat (15) @(negedge clk);
    rx_line = 1'b0;
    idle_run(20, "R3 restart");

    // R9: no ticks, no progress
    rx_line = 1'b0;
    send_char(9'h000);
    bit_tick = 1'b0;
    rx_line = 1'b1;
    repeat (300) @(negedge clk);
    check("R9 tick freeze", idle_flag, 1'b0);
    rx_line = 1'b0;
    bit_tick = 1'b1;

    // R8: off mode still flags idle but never wakes
    mode = 2'b11;
    idle_sel = 3'd0;
    idle_run(10, "R8 off idle");

    // R2: longest length, 128 characters of 10 ticks
    rx_line = 1'b0;
    mode = 2'b00;
    send_char(9'h000);
    idle_sel = 3'd7;
    idle_run(1280, "R2 idle 128x10");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule